// File: doc/BRIEF.md
# Register Rename Map Table

This block holds the architectural-to-physical register translation for an out-of-order core. It serves one unified architectural index space, split into three consecutive ranges. The lowest range holds the integer registers and the next range holds the floating-point registers; both classes are renamed. All indices above those two ranges are miscellaneous registers. These are never renamed and pass straight through to fixed physical slots placed above every renamable physical register.

A single rename port is provided each cycle. When it targets a renamable register it takes a fresh physical register from the external free list of that class and reports two things: the register it now allocates and the mapping it replaces. The designated integer zero register and the designated float zero register are never remapped. A combinational lookup port serves source operands. A set-entry port lets recovery logic rewrite any renamable mapping. The block also reports the smaller of the two free-list occupancy counts, so that rename can throttle on whichever class is scarcer.

Top module: `rename_map_table`

## Requirements
- R1: With default parameters, architectural indices 0..7 are integer, 8..15 are float and 16 and above are miscellaneous; the class decides which free list is used and which map is read.
- R2: After reset, integer register i maps to physical INT_BASE+i (default 0) and float register 8+j maps to physical FP_BASE+j (default 16).
- R3: A rename of a non-zero integer register with a non-empty integer free list raises `int_fl_pop` for that cycle. It drives `ren_new` with `int_fl_reg` and `ren_prev` with the old mapping, and the map holds the new value from the next clock edge.
- R4: A rename of a non-zero float register behaves the same way using the float free list. A float register taken from that list lies in [N_PINT, N_PINT+N_PFP), which is [16,32) by default.
- R5: A rename of the integer zero register (index 0) or the float zero register (index 8) pops nothing and leaves the map unchanged. It returns the zero register's own architectural index on `ren_new` and its current mapping on `ren_prev`.
- R6: A rename of a miscellaneous register pops nothing and never stalls. It returns (arch - 16) + 32 by default on both `ren_new` and `ren_prev`.
- R7: Lookup is combinational with no side effect. A lookup of a register being renamed in the same cycle returns the pre-rename mapping, and the new mapping is returned from the next cycle on.
- R8: A set-entry request writes `set_phys` into the map of an integer or float register from the next clock edge. A request that targets a miscellaneous index changes no mapping.
- R9: `free_count` equals the minimum of `int_fl_count` and `fp_fl_count`.
- R10: A rename of a non-zero renamable register whose free list is empty raises `ren_stall`, pops nothing and leaves the map unchanged.
- R11: When set-entry and rename target the same renamable register in one cycle, the set-entry value is written, the rename stalls and no free-list entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request |
| ren_arch | input | AW | Architectural index to rename |
| ren_new | output | PW | Newly assigned physical index |
| ren_prev | output | PW | Mapping replaced by the rename |
| ren_stall | output | 1 | Rename could not be accepted this cycle |
| int_fl_empty | input | 1 | Integer free list is empty |
| int_fl_reg | input | PW | Head of integer free list |
| int_fl_pop | output | 1 | Consume integer free-list head |
| int_fl_count | input | CW | Integer free-list occupancy |
| fp_fl_empty | input | 1 | Float free list is empty |
| fp_fl_reg | input | PW | Head of float free list |
| fp_fl_pop | output | 1 | Consume float free-list head |
| fp_fl_count | input | CW | Float free-list occupancy |
| lk_arch | input | AW | Architectural index to look up |
| lk_phys | output | PW | Current physical mapping |
| set_valid | input | 1 | Set-entry request |
| set_arch | input | AW | Architectural index to overwrite |
| set_phys | input | PW | Physical index to install |
| free_count | output | CW | Smaller of the two free-list counts |

## Verification
Several properties are checked on every cycle: the two pops never coincide, no pop happens on an empty list, on a stall, or for a zero or miscellaneous rename, a float pop carries an index in the float range, a miscellaneous rename reports identical new and previous values, and the minimum count never exceeds either input. The bench scenarios show the rest. These are the reset contents, how the map evolves over a sequence of renames, the pre-rename view on a same-cycle lookup, that a miscellaneous set-entry is discarded, and that set-entry wins a same-register collision.

// File: rtl/rnm_pkg.sv
// Package: shared class encoding for the rename map table.
// Assumes nothing beyond being compiled before the modules that import it.
package rnm_pkg;

    // Register class of an architectural index.
    typedef enum logic [1:0] {
        RC_INT  = 2'd0,
        RC_FP   = 2'd1,
        RC_MISC = 2'd2
    } rn_class_e;

endpackage

// File: rtl/rnm_decode.sv
// Module: rnm_decode
// Classifies one architectural index into integer, float or miscellaneous,
// gives its offset within its class, flags the class zero register and
// computes the pass-through physical index for miscellaneous registers.
// Assumes the index lies below N_LINT+N_LFP+N_MISC.
module rnm_decode
    import rnm_pkg::*;
#(
    parameter int N_LINT  = 8,
    parameter int N_LFP   = 8,
    parameter int N_PHYS  = 32,
    parameter int INT_ZERO = 0,
    parameter int FP_ZERO  = 8,
    parameter int AW      = 5,
    parameter int PW      = 6
) (
    input  logic [AW-1:0] arch,
    output rn_class_e     cls,
    output logic [AW-1:0] offset,
    output logic          is_zero,
    output logic [PW-1:0] misc_phys
);
    localparam logic [AW-1:0] LIM_INT = AW'(N_LINT);
    localparam logic [AW-1:0] LIM_ALL = AW'(N_LINT + N_LFP);
    localparam logic [AW-1:0] ZI      = AW'(INT_ZERO);
    localparam logic [AW-1:0] ZF      = AW'(FP_ZERO);
    localparam logic [PW-1:0] PHYS_P  = PW'(N_PHYS);
    localparam logic [PW-1:0] LALL_P  = PW'(N_LINT + N_LFP);

    // Class, in-class offset and zero flag.
    always_comb begin
        if (arch < LIM_INT) begin
            cls     = RC_INT;
            offset  = arch;
            is_zero = (arch == ZI);
        end else if (arch < LIM_ALL) begin
            cls     = RC_FP;
            offset  = arch - LIM_INT;
            is_zero = (arch == ZF);
        end else begin
            cls     = RC_MISC;
            offset  = arch - LIM_ALL;
            is_zero = 1'b0;
        end
    end

    // Fixed physical slot of a miscellaneous register.
    always_comb begin
        misc_phys = PW'(arch) - LALL_P + PHYS_P;
    end

endmodule

// File: rtl/rnm_map_bank.sv
// Module: rnm_map_bank
// Mapping storage for one renamed class: two combinational read ports and
// two write ports (set-entry port A has priority over rename port B).
// Reset loads entry i with BASE+i. Out-of-range indices read zero and
// are never written. Assumes DEPTH is a power of two, at least 2.
module rnm_map_bank #(
    parameter int DEPTH = 8,
    parameter int BASE  = 0,
    parameter int AW    = 5,
    parameter int PW    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd0_idx,
    output logic [PW-1:0] rd0_data,
    input  logic [AW-1:0] rd1_idx,
    output logic [PW-1:0] rd1_data,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_idx,
    input  logic [PW-1:0] wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_idx,
    input  logic [PW-1:0] wb_data
);
    localparam int            LIW = $clog2(DEPTH);
    localparam logic [AW-1:0] LIM = AW'(DEPTH);

    logic [PW-1:0] mem [DEPTH];

    // Read port 0 with range guard.
    always_comb begin
        rd0_data = '0;
        if (rd0_idx < LIM) rd0_data = mem[rd0_idx[LIW-1:0]];
    end

    // Read port 1 with range guard.
    always_comb begin
        rd1_data = '0;
        if (rd1_idx < LIM) rd1_data = mem[rd1_idx[LIW-1:0]];
    end

    // Reset to identity-with-base, then apply writes with port A first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= PW'(BASE + i);
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (wa_en && wa_idx == AW'(i))
                    mem[i] <= wa_data;
                else if (wb_en && wb_idx == AW'(i))
                    mem[i] <= wb_data;
            end
        end
    end

    // The two write ports never aim at the same entry (collision stalls rename).
    p_ports_distinct_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wb_en) |-> (wa_idx != wb_idx));

    // A set-entry write is visible on the next cycle.
    p_set_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wa_en && wa_idx < LIM) |=> (mem[$past(wa_idx[LIW-1:0])] == $past(wa_data)));

endmodule

// File: rtl/rnm_free_min.sv
// Module: rnm_free_min
// Reports the smaller of two free-list occupancy counts.
// Assumes both counts share the width CW.
module rnm_free_min #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_a,
    input  logic [CW-1:0] cnt_b,
    output logic [CW-1:0] cnt_min
);
    // Pick the smaller count.
    always_comb begin
        cnt_min = (cnt_a < cnt_b) ? cnt_a : cnt_b;
    end

    p_min_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_min <= cnt_a) && (cnt_min <= cnt_b) && ((cnt_min == cnt_a) || (cnt_min == cnt_b)));

endmodule

// File: rtl/rename_map_table.sv
// Module: rename_map_table
// Rename map for integer, float and miscellaneous registers in one
// architectural index space. One rename, one lookup and one set-entry
// per cycle. Rename results are combinational; map updates land at the
// next clock edge. Assumes the free-list heads are valid whenever their
// empty flags are low and that indices stay inside the declared ranges.
module rename_map_table
    import rnm_pkg::*;
#(
    parameter int N_LINT   = 8,
    parameter int N_LFP    = 8,
    parameter int N_MISC   = 4,
    parameter int N_PINT   = 16,
    parameter int N_PFP    = 16,
    parameter int INT_BASE = 0,
    parameter int FP_BASE  = 16,
    parameter int INT_ZERO = 0,
    parameter int FP_ZERO  = 8,
    parameter int CW       = 6,
    parameter int AW       = $clog2(N_LINT + N_LFP + N_MISC),
    parameter int PW       = $clog2(N_PINT + N_PFP + N_MISC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren_valid,
    input  logic [AW-1:0] ren_arch,
    output logic [PW-1:0] ren_new,
    output logic [PW-1:0] ren_prev,
    output logic          ren_stall,
    input  logic          int_fl_empty,
    input  logic [PW-1:0] int_fl_reg,
    output logic          int_fl_pop,
    input  logic [CW-1:0] int_fl_count,
    input  logic          fp_fl_empty,
    input  logic [PW-1:0] fp_fl_reg,
    output logic          fp_fl_pop,
    input  logic [CW-1:0] fp_fl_count,
    input  logic [AW-1:0] lk_arch,
    output logic [PW-1:0] lk_phys,
    input  logic          set_valid,
    input  logic [AW-1:0] set_arch,
    input  logic [PW-1:0] set_phys,
    output logic [CW-1:0] free_count
);
    localparam int            N_PHYS = N_PINT + N_PFP;
    localparam logic [PW-1:0] FP_LO  = PW'(N_PINT);
    localparam logic [PW-1:0] FP_HI  = PW'(N_PHYS);

    rn_class_e     r_cls, l_cls, s_cls;
    logic [AW-1:0] r_off, l_off, s_off;
    logic          r_zero, l_zero, s_zero;
    logic [PW-1:0] r_misc, l_misc, s_misc;

    rnm_decode #(.N_LINT(N_LINT), .N_LFP(N_LFP), .N_PHYS(N_PHYS),
                 .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .AW(AW), .PW(PW))
        u_dec_ren (.arch(ren_arch), .cls(r_cls), .offset(r_off),
                   .is_zero(r_zero), .misc_phys(r_misc));

    rnm_decode #(.N_LINT(N_LINT), .N_LFP(N_LFP), .N_PHYS(N_PHYS),
                 .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .AW(AW), .PW(PW))
        u_dec_lk (.arch(lk_arch), .cls(l_cls), .offset(l_off),
                  .is_zero(l_zero), .misc_phys(l_misc));

    rnm_decode #(.N_LINT(N_LINT), .N_LFP(N_LFP), .N_PHYS(N_PHYS),
                 .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO), .AW(AW), .PW(PW))
        u_dec_set (.arch(set_arch), .cls(s_cls), .offset(s_off),
                   .is_zero(s_zero), .misc_phys(s_misc));

    logic          int_need, fp_need, collide;
    logic          int_set, fp_set;
    logic [PW-1:0] int_rd_ren, int_rd_lk, fp_rd_ren, fp_rd_lk;

    // Demand for a fresh register and collision with a same-register set.
    always_comb begin
        int_need = ren_valid && (r_cls == RC_INT) && !r_zero;
        fp_need  = ren_valid && (r_cls == RC_FP)  && !r_zero;
        collide  = set_valid && (s_cls != RC_MISC) && (set_arch == ren_arch);
        int_set  = set_valid && (s_cls == RC_INT);
        fp_set   = set_valid && (s_cls == RC_FP);
    end

    // Pops and stall.
    always_comb begin
        int_fl_pop = int_need && !int_fl_empty && !collide;
        fp_fl_pop  = fp_need  && !fp_fl_empty  && !collide;
        ren_stall  = (int_need && (int_fl_empty || collide)) ||
                     (fp_need  && (fp_fl_empty  || collide));
    end

    // Rename results.
    always_comb begin
        unique case (r_cls)
            RC_INT: begin
                ren_prev = int_rd_ren;
                ren_new  = r_zero ? PW'(ren_arch) : int_fl_reg;
            end
            RC_FP: begin
                ren_prev = fp_rd_ren;
                ren_new  = r_zero ? PW'(ren_arch) : fp_fl_reg;
            end
            default: begin
                ren_prev = r_misc;
                ren_new  = r_misc;
            end
        endcase
    end

    // Lookup result.
    always_comb begin
        unique case (l_cls)
            RC_INT:  lk_phys = int_rd_lk;
            RC_FP:   lk_phys = fp_rd_lk;
            default: lk_phys = l_misc;
        endcase
    end

    rnm_map_bank #(.DEPTH(N_LINT), .BASE(INT_BASE), .AW(AW), .PW(PW)) u_int_map (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(r_off), .rd0_data(int_rd_ren),
        .rd1_idx(l_off), .rd1_data(int_rd_lk),
        .wa_en(int_set), .wa_idx(s_off), .wa_data(set_phys),
        .wb_en(int_fl_pop), .wb_idx(r_off), .wb_data(int_fl_reg));

    rnm_map_bank #(.DEPTH(N_LFP), .BASE(FP_BASE), .AW(AW), .PW(PW)) u_fp_map (
        .clk(clk), .rst_n(rst_n),
        .rd0_idx(r_off), .rd0_data(fp_rd_ren),
        .rd1_idx(l_off), .rd1_data(fp_rd_lk),
        .wa_en(fp_set), .wa_idx(s_off), .wa_data(set_phys),
        .wb_en(fp_fl_pop), .wb_idx(r_off), .wb_data(fp_fl_reg));

    rnm_free_min #(.CW(CW)) u_free (
        .clk(clk), .rst_n(rst_n),
        .cnt_a(int_fl_count), .cnt_b(fp_fl_count), .cnt_min(free_count));

    p_one_pop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({int_fl_pop, fp_fl_pop}));

    p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_fl_pop && int_fl_empty) && !(fp_fl_pop && fp_fl_empty));

    p_stall_no_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ren_stall |-> !(int_fl_pop || fp_fl_pop));

    p_zero_no_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && r_zero) |-> !(int_fl_pop || fp_fl_pop || ren_stall));

    p_fp_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fp_fl_pop |-> (fp_fl_reg >= FP_LO && fp_fl_reg < FP_HI));

    p_misc_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && r_cls == RC_MISC) |-> (ren_new == ren_prev && !ren_stall &&
                                              !int_fl_pop && !fp_fl_pop));

    p_collide_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && collide && !r_zero) |-> ren_stall);

endmodule

// File: tb/rename_map_table_test.sv
module rename_map_table_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int PW = 6;
    localparam int CW = 6;

    typedef struct packed {
        logic [4:0] arch;
        logic       ie;
        logic [5:0] ireg;
        logic       fe;
        logic [5:0] freg;
        logic [5:0] enew;
        logic [5:0] eprev;
        logic       estall;
        logic       eipop;
        logic       efpop;
    } vec_t;

    // Walked in order; each row sees the map left by the rows before it.
    localparam vec_t TBL [9] = '{
        '{5'd3,  1'b0, 6'd12, 1'b0, 6'd0,  6'd12, 6'd3,  1'b0, 1'b1, 1'b0}, // R3
        '{5'd3,  1'b0, 6'd13, 1'b0, 6'd0,  6'd13, 6'd12, 1'b0, 1'b1, 1'b0}, // R3
        '{5'd10, 1'b0, 6'd0,  1'b0, 6'd28, 6'd28, 6'd18, 1'b0, 1'b0, 1'b1}, // R4
        '{5'd0,  1'b0, 6'd14, 1'b0, 6'd0,  6'd0,  6'd0,  1'b0, 1'b0, 1'b0}, // R5
        '{5'd8,  1'b0, 6'd0,  1'b0, 6'd29, 6'd8,  6'd16, 1'b0, 1'b0, 1'b0}, // R5
        '{5'd17, 1'b0, 6'd0,  1'b0, 6'd0,  6'd33, 6'd33, 1'b0, 1'b0, 1'b0}, // R6
        '{5'd5,  1'b1, 6'd0,  1'b0, 6'd0,  6'd0,  6'd5,  1'b1, 1'b0, 1'b0}, // R10
        '{5'd15, 1'b0, 6'd0,  1'b0, 6'd31, 6'd31, 6'd23, 1'b0, 1'b0, 1'b1}, // R4
        '{5'd9,  1'b0, 6'd0,  1'b1, 6'd0,  6'd0,  6'd17, 1'b1, 1'b0, 1'b0}  // R10
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ren_valid = 1'b0;
    logic [AW-1:0] ren_arch = '0;
    logic [PW-1:0] ren_new, ren_prev;
    logic          ren_stall;
    logic          int_fl_empty = 1'b0;
    logic [PW-1:0] int_fl_reg = '0;
    logic          int_fl_pop;
    logic [CW-1:0] int_fl_count = '0;
    logic          fp_fl_empty = 1'b0;
    logic [PW-1:0] fp_fl_reg = 6'd16;
    logic          fp_fl_pop;
    logic [CW-1:0] fp_fl_count = '0;
    logic [AW-1:0] lk_arch = '0;
    logic [PW-1:0] lk_phys;
    logic          set_valid = 1'b0;
    logic [AW-1:0] set_arch = '0;
    logic [PW-1:0] set_phys = '0;
    logic [CW-1:0] free_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rename_map_table uut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_new(ren_new),
        .ren_prev(ren_prev), .ren_stall(ren_stall),
        .int_fl_empty(int_fl_empty), .int_fl_reg(int_fl_reg),
        .int_fl_pop(int_fl_pop), .int_fl_count(int_fl_count),
        .fp_fl_empty(fp_fl_empty), .fp_fl_reg(fp_fl_reg),
        .fp_fl_pop(fp_fl_pop), .fp_fl_count(fp_fl_count),
        .lk_arch(lk_arch), .lk_phys(lk_phys),
        .set_valid(set_valid), .set_arch(set_arch), .set_phys(set_phys),
        .free_count(free_count));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
        end
    endtask

    // Look up one index at mid-cycle and compare.
    task automatic look(input string req, input int arch, input int expected);
        @(negedge clk);
        lk_arch = AW'(arch);
        #1;
        check(req, $sformatf("lookup %0d", arch), int'(lk_phys), expected);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // Reset contents
        look("R2", 7, 7);
        look("R2", 15, 23);
        look("R2", 3, 3);
        check("R2", "idle int pop", int'(int_fl_pop), 0);
        check("R2", "idle fp pop", int'(fp_fl_pop), 0);

        // Table walk
        for (int k = 0; k < 9; k++) begin
            @(negedge clk);
            ren_valid    = 1'b1;
            ren_arch     = TBL[k].arch;
            int_fl_empty = TBL[k].ie;
            int_fl_reg   = TBL[k].ireg;
            fp_fl_empty  = TBL[k].fe;
            fp_fl_reg    = (TBL[k].freg == 0) ? 6'd16 : TBL[k].freg;
            #1;
            check("R3 R4 R5 R6 R10", $sformatf("row %0d stall", k), int'(ren_stall), int'(TBL[k].estall));
            check("R3 R4 R5 R6 R10", $sformatf("row %0d int pop", k), int'(int_fl_pop), int'(TBL[k].eipop));
            check("R3 R4 R5 R6 R10", $sformatf("row %0d fp pop", k), int'(fp_fl_pop), int'(TBL[k].efpop));
            check("R3 R4 R5 R6 R10", $sformatf("row %0d prev", k), int'(ren_prev), int'(TBL[k].eprev));
            if (!TBL[k].estall)
                check("R3 R4 R5 R6 R10", $sformatf("row %0d new", k), int'(ren_new), int'(TBL[k].enew));
        end
        @(negedge clk);
        ren_valid = 1'b0;
        int_fl_empty = 1'b0;
        fp_fl_empty = 1'b0;

        // Map after the table
        look("R3", 3, 13);
        look("R4", 10, 28);
        look("R4", 15, 31);
        look("R10", 5, 5);
        look("R10", 9, 17);
        look("R5", 0, 0);
        look("R5", 8, 16);
        look("R1", 19, 35);
        look("R1", 7, 7);

        // R7: same-cycle lookup sees the old mapping
        @(negedge clk);
        ren_valid = 1'b1; ren_arch = 5'd4; int_fl_reg = 6'd15; lk_arch = 5'd4;
        #1;
        check("R7", "same-cycle lookup", int'(lk_phys), 4);
        check("R7", "same-cycle prev", int'(ren_prev), 4);
        @(negedge clk);
        ren_valid = 1'b0;
        #1;
        check("R7", "lookup after rename", int'(lk_phys), 15);

        // R8: set-entry on int, float and misc
        @(negedge clk);
        set_valid = 1'b1; set_arch = 5'd6; set_phys = 6'd9;
        @(negedge clk);
        set_arch = 5'd12; set_phys = 6'd30;
        @(negedge clk);
        set_arch = 5'd18; set_phys = 6'd3;
        @(negedge clk);
        set_valid = 1'b0;
        look("R8", 6, 9);
        look("R8", 12, 30);
        look("R8", 18, 34);
        look("R8", 2, 2);
        look("R8", 10, 28);
        look("R8", 11, 19);

        // R11: set and rename on the same register
        @(negedge clk);
        set_valid = 1'b1; set_arch = 5'd7; set_phys = 6'd11;
        ren_valid = 1'b1; ren_arch = 5'd7; int_fl_reg = 6'd10;
        #1;
        check("R11", "collide stall", int'(ren_stall), 1);
        check("R11", "collide int pop", int'(int_fl_pop), 0);
        @(negedge clk);
        set_valid = 1'b0; ren_valid = 1'b0;
        look("R11", 7, 11);

        // R9: free count minimum
        @(negedge clk);
        int_fl_count = 6'd5; fp_fl_count = 6'd3;
        #1; check("R9", "min fp smaller", int'(free_count), 3);
        int_fl_count = 6'd2; fp_fl_count = 6'd9;
        #1; check("R9", "min int smaller", int'(free_count), 2);
        int_fl_count = 6'd7; fp_fl_count = 6'd7;
        #1; check("R9", "min equal", int'(free_count), 7);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule